// File: doc/BRIEF.md
# Video RAM Block Copy Engine

The block moves data from anywhere in a 16-bit CPU address space into the 8 KiB video RAM window at 0x8000–0x9FFF. It always works in 16-byte chunks. Software loads a source pointer and a destination pointer through four byte registers. It then writes a control byte that selects the mode and gives a length of 1 to 128 chunks.

There are two modes. In the bulk mode the whole length is copied at once while the CPU is held off. In the blank-paced mode one chunk is copied each time the external video timing enters its horizontal-blank mode (mode 0). Between chunks the CPU runs freely. While a blank-paced job is running, the control register shows the number of chunks left, minus one. When the block is idle the control register reads 0xFF.

Each byte takes a bus read followed, one cycle later, by a bus write. The read data is expected one cycle after the read strobe. The block stalls the CPU for the whole length of every burst. When a burst ends, it returns the advanced pointers through the address registers.

Top module: `vram_block_dma`

## Requirements
- R1: After reset the control register (select 4) reads 0xFF, all address registers read 0x00, `cpu_stall` is low and neither bus strobe is active.
- R2: A burst reads from {src_hi, src_lo} with the low 4 bits forced to zero, and the source pointer advances by one per byte over the full 16-bit space.
- R3: A burst writes to 0x8000 | ({dst_hi, dst_lo} & 0x1FF0). The 13-bit offset advances by one per byte and wraps from 0x9FFF to 0x8000.
- R4: When the aligned source lies in 0x8000–0x9FFF, a control write is ignored: no transfer starts and the control register keeps its value. A source of 0x7FF0 is accepted.
- R5: A control write with bit 7 clear starts a bulk copy of (bits[6:0]+1)×16 bytes. `cpu_stall` is high from the clock edge that accepts the write until the edge after the last bus write, which is 2 cycles per byte. After the copy the control register reads 0xFF.
- R6: Each byte is a read strobe in one cycle and a write strobe carrying the returned data in the next cycle. Both strobes are never high in the same cycle.
- R7: At the end of every burst the address registers hold the advanced pointers. The register select codes are 0 = source high, 1 = source low, 2 = destination high (read back as 0x80 | offset[12:8]), 3 = destination low and 4 = control.
- R8: A control write with bit 7 set starts the blank-paced mode, and the control register then reads {0, bits[6:0]}. Exactly one 16-byte chunk is copied each time `video_mode` changes from a nonzero value to 0, with no copy while it stays at 0. The control register is decremented after each chunk, and the mode ends when it wraps to 0xFF.
- R9: A blank-paced request written while `video_mode` is 0 copies its first chunk immediately.
- R10: A control write with bit 7 clear while the blank-paced mode is active cancels that mode without copying. The control register then reads back with bit 7 set and the remaining count kept.
- R11: Register writes of any select are ignored while `cpu_stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0–4) for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the selected register |
| video_mode | input | 2 | Current video timing mode, 0 = horizontal blank |
| bus_rd_en | output | 1 | Source read strobe |
| bus_rd_addr | output | 16 | Source read address |
| bus_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| bus_wr_en | output | 1 | Video RAM write strobe |
| bus_wr_addr | output | 16 | Video RAM write address |
| bus_wr_data | output | 8 | Video RAM write data |
| cpu_stall | output | 1 | Holds the CPU off during a burst |

## Verification
The bench runs bulk copies from an unaligned source and from a source whose aligned value sits one chunk below video RAM. These show that alignment is applied and that the rejection boundary falls at 0x8000. A destination near the top of the window shows whether the offset wraps inside video RAM instead of running past it. Blank-paced jobs are started both outside and inside mode 0 and driven by mode changes, including a long stay in mode 0. This separates a copy on entry into mode 0 from a copy on level, and it separates an immediate first chunk from a deferred one. A cancel followed by a new bulk job checks the status bit and shows that the write-back pointers carry over to the next job.

// File: rtl/vram_dma_pkg.sv
package vram_dma_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int LEN_W  = DATA_W - 1;           // length field of the control byte
    localparam int VOFF_W = 13;                   // offset bits inside the video RAM window
    localparam logic [ADDR_W-VOFF_W-1:0] VRAM_TAG = 3'b100;

    typedef enum logic [2:0] {
        SEL_SRC_HI = 3'd0,
        SEL_SRC_LO = 3'd1,
        SEL_DST_HI = 3'd2,
        SEL_DST_LO = 3'd3,
        SEL_CTRL   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_READ  = 2'd1,
        MV_WRITE = 2'd2
    } mover_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [VOFF_W-1:0] dst;
    } ptr_pair_t;

    function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                      input int lg);
        return a & ~((ADDR_W'(1) << lg) - ADDR_W'(1));
    endfunction

    function automatic logic in_vram(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:VOFF_W] == VRAM_TAG;
    endfunction

endpackage

// File: rtl/vram_dma_blank_edge.sv
module vram_dma_blank_edge #(
    parameter int VMODE_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VMODE_W-1:0] video_mode,
    output logic               enter_blank
);
    logic [VMODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= video_mode;
    end

    // one pulse on the cycle the timing generator arrives in mode 0
    assign enter_blank = (video_mode == '0) && (mode_q != '0);
endmodule

// File: rtl/vram_dma_mover.sv
module vram_dma_mover
    import vram_dma_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ptr_pair_t         start_ptr,
    input  logic [CNT_W-1:0]  start_cnt,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output ptr_pair_t         end_ptr
);
    mover_state_e     state;
    ptr_pair_t        cur;
    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MV_IDLE;
            cur   <= '0;
            left  <= '0;
        end else begin
            case (state)
                MV_IDLE: begin
                    if (start) begin
                        cur   <= start_ptr;
                        left  <= start_cnt;
                        state <= MV_READ;
                    end
                end
                MV_READ: state <= MV_WRITE;
                MV_WRITE: begin
                    cur.src <= cur.src + 1'b1;
                    cur.dst <= cur.dst + 1'b1;
                    left    <= left - 1'b1;
                    state   <= (left == CNT_W'(1)) ? MV_IDLE : MV_READ;
                end
                default: state <= MV_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_en   = (state == MV_READ);
        rd_addr = cur.src;
        wr_en   = (state == MV_WRITE);
        wr_addr = {VRAM_TAG, cur.dst};
        wr_data = rd_data;
        busy    = (state != MV_IDLE);
        done    = wr_en && (left == CNT_W'(1));
        end_ptr = '{src: cur.src + 1'b1, dst: cur.dst + 1'b1};
    end
endmodule

// File: rtl/vram_dma_regs.sv
module vram_dma_regs
    import vram_dma_pkg::*;
#(
    parameter int CHUNK_LG = 4,
    parameter int CNT_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              enter_blank,
    input  logic              in_blank,
    input  logic              busy,
    input  logic              done,
    input  ptr_pair_t         end_ptr,
    output logic              start,
    output ptr_pair_t         start_ptr,
    output logic [CNT_W-1:0]  start_cnt
);
    logic [DATA_W-1:0] src_hi, src_lo, dst_hi, dst_lo, ctrl;
    logic              paced_on;   // blank-paced job pending
    logic              paced_run;  // current burst belongs to it

    logic [ADDR_W-1:0] src_al;
    logic [VOFF_W-1:0] dst_off;
    logic              ctrl_wr, accept, cancel, launch, launch_now, chunk_go;
    logic [CNT_W-1:0]  bulk_bytes;

    always_comb begin
        src_al     = align_down({src_hi, src_lo}, CHUNK_LG);
        dst_off    = VOFF_W'(align_down({dst_hi, dst_lo}, CHUNK_LG));
        ctrl_wr    = reg_we && !busy && (reg_sel == SEL_CTRL);
        accept     = ctrl_wr && !in_vram(src_al);
        cancel     = accept && paced_on && !reg_wdata[DATA_W-1];
        launch     = accept && !cancel;
        launch_now = launch && (!reg_wdata[DATA_W-1] || in_blank);
        chunk_go   = !accept && paced_on && enter_blank && !busy;
        bulk_bytes = (CNT_W'(reg_wdata[LEN_W-1:0]) + CNT_W'(1)) << CHUNK_LG;
        start      = launch_now || chunk_go;
        start_ptr  = '{src: src_al, dst: dst_off};
        start_cnt  = (launch_now && !reg_wdata[DATA_W-1]) ? bulk_bytes
                                                          : (CNT_W'(1) << CHUNK_LG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_hi    <= '0;
            src_lo    <= '0;
            dst_hi    <= '0;
            dst_lo    <= '0;
            ctrl      <= '1;
            paced_on  <= 1'b0;
            paced_run <= 1'b0;
        end else if (done) begin
            src_hi <= end_ptr.src[ADDR_W-1:DATA_W];
            src_lo <= end_ptr.src[DATA_W-1:0];
            dst_hi <= {VRAM_TAG, end_ptr.dst[VOFF_W-1:DATA_W]};
            dst_lo <= end_ptr.dst[DATA_W-1:0];
            if (paced_run) begin
                ctrl <= ctrl - 1'b1;
                if (ctrl[LEN_W-1:0] == '0) paced_on <= 1'b0;
            end else begin
                ctrl <= '1;
            end
        end else begin
            if (reg_we && !busy) begin
                case (reg_sel)
                    SEL_SRC_HI: src_hi <= reg_wdata;
                    SEL_SRC_LO: src_lo <= reg_wdata;
                    SEL_DST_HI: dst_hi <= reg_wdata;
                    SEL_DST_LO: dst_lo <= reg_wdata;
                    SEL_CTRL: begin
                        if (cancel) begin
                            paced_on <= 1'b0;
                            ctrl     <= ctrl | {1'b1, {LEN_W{1'b0}}};
                        end else if (launch) begin
                            paced_on  <= reg_wdata[DATA_W-1];
                            paced_run <= reg_wdata[DATA_W-1];
                            ctrl      <= {1'b0, reg_wdata[LEN_W-1:0]};
                        end
                    end
                    default: ;
                endcase
            end
            if (chunk_go) paced_run <= 1'b1;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_SRC_HI: reg_rdata = src_hi;
            SEL_SRC_LO: reg_rdata = src_lo;
            SEL_DST_HI: reg_rdata = dst_hi;
            SEL_DST_LO: reg_rdata = dst_lo;
            SEL_CTRL:   reg_rdata = ctrl;
            default:    reg_rdata = '1;
        endcase
    end
endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
    import vram_dma_pkg::*;
#(
    parameter int CHUNK_LG = 4,
    parameter int VMODE_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [2:0]         reg_sel,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [VMODE_W-1:0] video_mode,
    output logic               bus_rd_en,
    output logic [15:0]        bus_rd_addr,
    input  logic [7:0]         bus_rd_data,
    output logic               bus_wr_en,
    output logic [15:0]        bus_wr_addr,
    output logic [7:0]         bus_wr_data,
    output logic               cpu_stall
);
    localparam int CNT_W = LEN_W + CHUNK_LG + 1;

    logic             enter_blank, busy, done, start;
    ptr_pair_t        start_ptr, end_ptr;
    logic [CNT_W-1:0] start_cnt;

    vram_dma_blank_edge #(.VMODE_W(VMODE_W)) i_edge (
        .clk(clk), .rst(rst), .video_mode(video_mode), .enter_blank(enter_blank)
    );

    vram_dma_regs #(.CHUNK_LG(CHUNK_LG), .CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .enter_blank(enter_blank), .in_blank(video_mode == '0),
        .busy(busy), .done(done), .end_ptr(end_ptr),
        .start(start), .start_ptr(start_ptr), .start_cnt(start_cnt)
    );

    vram_dma_mover #(.CNT_W(CNT_W)) i_mover (
        .clk(clk), .rst(rst),
        .start(start), .start_ptr(start_ptr), .start_cnt(start_cnt),
        .rd_en(bus_rd_en), .rd_addr(bus_rd_addr), .rd_data(bus_rd_data),
        .wr_en(bus_wr_en), .wr_addr(bus_wr_addr), .wr_data(bus_wr_data),
        .busy(busy), .done(done), .end_ptr(end_ptr)
    );

    assign cpu_stall = busy;
endmodule

// File: rtl/vram_dma_checker.sv
module vram_dma_checker (
    input logic       clk,
    input logic       rst,
    input logic       cpu_stall,
    input logic       rd_en,
    input logic       wr_en,
    input logic [2:0] wr_tag
);
    assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

    assert_wr_after_rd_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(rd_en));

    assert_rd_then_wr_R6: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> wr_en);

    assert_dst_window_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_tag == 3'b100));

    assert_stall_covers_bus_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |-> cpu_stall);

    assert_release_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_stall) |-> $past(wr_en));
endmodule

bind vram_block_dma vram_dma_checker i_chk (
    .clk(clk), .rst(rst), .cpu_stall(cpu_stall),
    .rd_en(bus_rd_en), .wr_en(bus_wr_en), .wr_tag(bus_wr_addr[15:13])
);

// File: tb/test_vram_block_dma.sv
module test_vram_block_dma;
    localparam logic [2:0] S_SH = 3'd0, S_SL = 3'd1, S_DH = 3'd2, S_DL = 3'd3, S_CT = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [1:0]  video_mode = 2'd3;
    logic        bus_rd_en, bus_wr_en, cpu_stall;
    logic [15:0] bus_rd_addr, bus_wr_addr;
    logic [7:0]  bus_rd_data = '0;
    logic [7:0]  bus_wr_data;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct packed { logic [15:0] a; logic [7:0] d; } wr_item_t;
    wr_item_t exp_q[$];

    always #5 clk = ~clk;

    vram_block_dma i_vram_block_dma (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .video_mode(video_mode),
        .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
        .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .cpu_stall(cpu_stall)
    );

    function automatic logic [7:0] src_pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    // source memory: data one cycle after the strobe
    always @(posedge clk) if (bus_rd_en) bus_rd_data <= src_pat(bus_rd_addr);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compare every write against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && bus_wr_en) begin
            if (exp_q.size() == 0) begin
                chk("R3/R4/R8 unexpected write addr", bus_wr_addr, 16'hxxxx);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk("R3 write address", bus_wr_addr, it.a);
                chk("R2/R6 write data", {8'h00, bus_wr_data}, {8'h00, it.d});
            end
        end
    end

    task automatic push_burst(input logic [15:0] src, input logic [12:0] off, input int n);
        for (int i = 0; i < n; i++) begin
            logic [12:0] o;
            logic [15:0] s;
            o = off + 13'(i);
            s = src + 16'(i);
            exp_q.push_back('{a: {3'b100, o}, d: src_pat(s)});
        end
    endtask

    task automatic wr_reg(input logic [2:0] sel, input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] sel, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        chk(req, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic load_ptrs(input logic [15:0] s, input logic [15:0] d);
        wr_reg(S_SH, s[15:8]); wr_reg(S_SL, s[7:0]);
        wr_reg(S_DH, d[15:8]); wr_reg(S_DL, d[7:0]);
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (cpu_stall && cyc < 5000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic blank_entry();
        @(negedge clk); video_mode = 2'd3;
        @(negedge clk); video_mode = 2'd0;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 stall", {15'h0, cpu_stall}, 16'h0);
        chk("R1 strobes", {14'h0, bus_rd_en, bus_wr_en}, 16'h0);
        chk_reg("R1 ctrl", S_CT, 8'hFF);
        chk_reg("R1 src_hi", S_SH, 8'h00);

        // R5 bulk copy, unaligned source and destination (R2, R3)
        load_ptrs(16'h1234, 16'hFF45);
        push_burst(16'h1230, 13'h1F40, 32);
        wr_reg(S_CT, 8'h01);
        chk("R5 stall on start", {15'h0, cpu_stall}, 16'h1);
        wait_idle(cyc);
        chk("R5 stall length", 16'(cyc), 16'd64);
        chk_reg("R5 ctrl idle", S_CT, 8'hFF);
        chk_reg("R7 src_hi", S_SH, 8'h12);
        chk_reg("R7 src_lo", S_SL, 8'h50);
        chk_reg("R7 dst_hi", S_DH, 8'h9F);
        chk_reg("R7 dst_lo", S_DL, 8'h60);

        // R4 source inside video RAM is rejected
        load_ptrs(16'h9ABC, 16'h0000);
        wr_reg(S_CT, 8'h03);
        chk("R4 no stall", {15'h0, cpu_stall}, 16'h0);
        repeat (4) @(negedge clk);
        chk_reg("R4 ctrl unchanged", S_CT, 8'hFF);

        // R4 boundary: 0x7FFx accepted, reads run into 0x8000
        load_ptrs(16'h7FFF, 16'h0000);
        push_burst(16'h7FF0, 13'h0000, 16);
        wr_reg(S_CT, 8'h00);
        wait_idle(cyc);
        chk("R4 boundary accepted", 16'(cyc), 16'd32);
        chk_reg("R7 src wraps to 0x80", S_SH, 8'h80);

        // R3 destination wraps inside the window; R11 writes while busy ignored
        load_ptrs(16'h4008, 16'h1FF7);
        push_burst(16'h4000, 13'h1FF0, 32);
        wr_reg(S_CT, 8'h01);
        wr_reg(S_SH, 8'h77);
        wr_reg(S_CT, 8'h05);
        wait_idle(cyc);
        chk_reg("R11 src_hi kept", S_SH, 8'h40);
        chk_reg("R11 ctrl kept", S_CT, 8'hFF);
        chk_reg("R3 dst_hi wrapped", S_DH, 8'h80);
        chk_reg("R3 dst_lo wrapped", S_DL, 8'h10);

        // R8 blank-paced job started outside mode 0
        @(negedge clk); video_mode = 2'd3;
        load_ptrs(16'hC000, 16'h0100);
        wr_reg(S_CT, 8'h82);
        chk("R8 no immediate copy", {15'h0, cpu_stall}, 16'h0);
        chk_reg("R8 ctrl count", S_CT, 8'h02);
        push_burst(16'hC000, 13'h0100, 16);
        blank_entry();
        chk("R8 chunk stall", {15'h0, cpu_stall}, 16'h1);
        wait_idle(cyc);
        chk("R8 one chunk", 16'(cyc), 16'd32);
        chk_reg("R8 ctrl dec", S_CT, 8'h01);
        chk_reg("R7 src_lo chunk", S_SL, 8'h10);
        repeat (10) @(negedge clk);
        chk("R8 level no copy", {15'h0, cpu_stall}, 16'h0);
        chk_reg("R8 ctrl held", S_CT, 8'h01);
        push_burst(16'hC010, 13'h0110, 16);
        blank_entry();
        wait_idle(cyc);
        chk_reg("R8 ctrl zero", S_CT, 8'h00);
        push_burst(16'hC020, 13'h0120, 16);
        blank_entry();
        wait_idle(cyc);
        chk_reg("R8 ctrl wrapped", S_CT, 8'hFF);
        chk_reg("R7 dst_lo paced", S_DL, 8'h30);
        blank_entry();
        chk("R8 ended no copy", {15'h0, cpu_stall}, 16'h0);
        chk_reg("R8 ctrl stays", S_CT, 8'hFF);

        // R9 blank-paced request while in mode 0
        load_ptrs(16'h0200, 16'h0400);
        push_burst(16'h0200, 13'h0400, 16);
        wr_reg(S_CT, 8'h81);
        chk("R9 immediate stall", {15'h0, cpu_stall}, 16'h1);
        wait_idle(cyc);
        chk("R9 one chunk", 16'(cyc), 16'd32);
        chk_reg("R9 ctrl", S_CT, 8'h00);
        push_burst(16'h0210, 13'h0410, 16);
        blank_entry();
        wait_idle(cyc);
        chk_reg("R9 finished", S_CT, 8'hFF);

        // R10 cancel a blank-paced job
        @(negedge clk); video_mode = 2'd3;
        load_ptrs(16'hD000, 16'h0000);
        wr_reg(S_CT, 8'h85);
        chk_reg("R8 ctrl start", S_CT, 8'h05);
        push_burst(16'hD000, 13'h0000, 16);
        blank_entry();
        wait_idle(cyc);
        chk_reg("R10 before cancel", S_CT, 8'h04);
        @(negedge clk); video_mode = 2'd3;
        wr_reg(S_CT, 8'h00);
        chk("R10 no copy", {15'h0, cpu_stall}, 16'h0);
        chk_reg("R10 ctrl bit7", S_CT, 8'h84);
        blank_entry();
        chk("R10 entry ignored", {15'h0, cpu_stall}, 16'h0);
        chk_reg("R10 ctrl kept", S_CT, 8'h84);
        push_burst(16'hD010, 13'h0010, 16);
        wr_reg(S_CT, 8'h00);
        wait_idle(cyc);
        chk("R5 bulk after cancel", 16'(cyc), 16'd32);
        chk_reg("R5 ctrl after bulk", S_CT, 8'hFF);

        repeat (4) @(negedge clk);
        chk("R2 scoreboard drained", 16'(exp_q.size()), 16'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule